// File: doc/BRIEF.md
# Banked External Interrupt Trigger Controller

This block gathers peripheral interrupt lines in groups of 32, one group per bank, with one to four banks. It latches each line into a per-bank status register and sends every pending, enabled line to one of several CPU thread trigger outputs. Each line has its own sense bit, which selects edge or level detection. It also has an optional mask bit and a small vector register that names the one thread it signals, or none.

Software uses a plain register port with a byte address, a write strobe and a combinational read bus. A write of one to a status bit of an edge line toggles that bit. Writing one to a set bit acknowledges the interrupt. Writing one to a clear bit raises a fresh trigger, so software can retrigger an edge interrupt with a double toggle. Every thread trigger is an active-low level.

Top module: `ext_trig_ctrl`

## Requirements
- R1: After reset every status, sense, mask and vector register reads zero, and every trigger output is high (deasserted).
- R2: Register decode. Byte address bit 11 = 0 selects a bank register: bits 7:6 pick the kind (0 status, 1 sense, 2 mask, 3 reads zero and ignores writes), and bits 4:3 pick the bank. Bit 11 = 1 selects a vector register: bits 9:8 pick the bank and bits 6:2 pick the line. Bit n of a bank register belongs to line 32*bank+n. Registers of banks at or above NBANKS read zero, and writes to them have no effect.
- R3: A line with sense bit 0 (edge) sets its status bit on a rising edge of its input after a two-stage synchronizer. The bit reads one three clock edges after the input rises. A falling input never clears the bit.
- R4: A line with sense bit 1 (level) has a status bit that follows its synchronized input. Software writes to that status bit have no effect.
- R5: On an edge line, writing 1 to a status bit toggles it, and writing 0 leaves it unchanged. A write of 1 to a set bit clears it (acknowledge). A write of 1 to a clear bit sets it and raises a new trigger. A rising input in the same cycle as a toggle leaves the bit set.
- R6: The sense bits change only on a write to a sense register.
- R7: When masks are built in, mask bit 1 lets a pending line drive its thread and mask bit 0 blocks it. The status bit is captured regardless of the mask.
- R8: When masks are left out (HAS_MASK = 0), mask registers read zero and ignore writes, and every line counts as enabled. Routing is then the only gate.
- R9: Each line's vector register stores a 3-bit code that reads back unchanged. Code k in 1..NTHR routes the line to thread k-1. Code 0, and any code above NTHR, routes it nowhere. A line drives at most one thread.
- R10: trig_n[t] is driven low exactly while some line has its status bit set, is enabled, and holds vector code t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NBANKS*32 | Asynchronous peripheral interrupt lines |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| trig_n | output | NTHR | Active-low thread trigger levels |

## Verification
The assertions check several properties on every cycle. Level lines copy their synchronized input. A synchronized rising edge on an edge line always leaves its status bit set. Set edge bits survive any cycle without a write. Sense bits hold unless written. No trigger is low while nothing is pending and enabled.

Only the bench's scenarios can show some other behaviours: the write-one toggle with acknowledge and double-toggle retrigger, the effect of the mask, the decoding of each vector code to the right thread, the reads and writes of banks that are not built, and the build without masks. The bench checks these against a register-level model driven by seeded random and directed operations.

// File: rtl/ext_trig_ctrl.sv
module ext_trig_ctrl #(
  parameter int NBANKS = 4,
  parameter int NTHR = 4,
  parameter bit HAS_MASK = 1'b1,
  localparam int NL = NBANKS * 32,
  localparam int VW = $clog2(NTHR + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NL-1:0]   irq_in,
  input  logic [11:0]     bus_addr,
  input  logic            bus_we,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NTHR-1:0] trig_n
);

  logic [NL-1:0] sy1, sy2, sy3, stat, sense, mask, en, bsm, tog;
  logic [VW-1:0] vec [NL];

  wire       is_vec  = bus_addr[11];
  wire [1:0] kind    = bus_addr[7:6];
  wire [1:0] bsel    = is_vec ? bus_addr[9:8] : bus_addr[4:3];
  wire [6:0] lsel    = {bsel, bus_addr[6:2]};
  wire       bank_ok = int'(bsel) < NBANKS;
  wire       wr_ok   = bus_we && bank_ok;
  wire       wr_st   = wr_ok && !is_vec && kind == 2'd0;
  wire       wr_se   = wr_ok && !is_vec && kind == 2'd1;
  wire       wr_mk   = wr_ok && !is_vec && kind == 2'd2;
  wire       wr_vec  = wr_ok && is_vec;
  wire [NL-1:0] wrep = {NBANKS{bus_wdata}};
  wire [NL-1:0] rise = sy2 & ~sy3;

  always_comb
    for (int b = 0; b < NBANKS; b++) bsm[b*32 +: 32] = {32{bsel == 2'(b)}};

  assign tog = wr_st ? (bsm & wrep) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
      stat <= '0; sense <= '0;
    end else begin
      sy1 <= irq_in; sy2 <= sy1; sy3 <= sy2;
      stat <= (sense & sy2) | (~sense & ((stat ^ tog) | rise));
      if (wr_se) sense <= (sense & ~bsm) | (wrep & bsm);
    end
  end

  generate
    if (HAS_MASK) begin : g_mask
      always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else if (wr_mk) mask <= (mask & ~bsm) | (wrep & bsm);
      end
      assign en = mask;
    end else begin : g_nomask
      assign mask = '0;
      assign en = '1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (!rst_n) vec[l] <= '0;
      else if (wr_vec && lsel == 7'(l)) vec[l] <= bus_wdata[VW-1:0];
    end
  end

  generate
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int l = 0; l < NL; l++)
          if (stat[l] && en[l] && vec[l] == VW'(t + 1)) hit = 1'b1;
      end
      assign trig_n[t] = ~hit;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bank_ok) begin
      if (is_vec) begin
        for (int l = 0; l < NL; l++)
          if (lsel == 7'(l)) bus_rdata = 32'(vec[l]);
      end else begin
        for (int b = 0; b < NBANKS; b++)
          if (bsel == 2'(b))
            case (kind)
              2'd0:    bus_rdata = stat[b*32 +: 32];
              2'd1:    bus_rdata = sense[b*32 +: 32];
              2'd2:    bus_rdata = mask[b*32 +: 32];
              default: bus_rdata = '0;
            endcase
      end
    end
  end

endmodule

// File: rtl/ext_trig_ctrl_chk.sv
module ext_trig_ctrl_chk #(
  parameter int NL = 128,
  parameter int NTHR = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NL-1:0]   stat,
  input logic [NL-1:0]   sense,
  input logic [NL-1:0]   en,
  input logic [NL-1:0]   sy2,
  input logic [NL-1:0]   sy3,
  input logic            bus_we,
  input logic [NTHR-1:0] trig_n
);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stat == '0 && trig_n == '1));

  p_edge_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~sense & sy2 & ~sy3) & ~stat) == '0));

  p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(sense)) == ($past(sy2) & $past(sense))));

  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> (($past(~sense & stat) & ~stat) == '0));

  p_sense_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(sense));

  p_idle_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & en) == '0) |-> (trig_n == '1));

endmodule

bind ext_trig_ctrl ext_trig_ctrl_chk #(.NL(NL), .NTHR(NTHR)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat(stat), .sense(sense), .en(en),
  .sy2(sy2), .sy3(sy3), .bus_we(bus_we), .trig_n(trig_n)
);

// File: tb/sim_ext_trig_ctrl.sv
module sim_ext_trig_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [95:0] irq;
  logic [11:0] addr;
  logic        we;
  logic [31:0] wd, rd;
  logic [3:0]  trig;

  logic [31:0] irq1;
  logic [11:0] a1;
  logic        we1;
  logic [31:0] wd1, rd1;
  logic [3:0]  trig1;

  ext_trig_ctrl #(.NBANKS(3)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wd), .bus_rdata(rd), .trig_n(trig));

  ext_trig_ctrl #(.NBANKS(1), .HAS_MASK(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq1), .bus_addr(a1), .bus_we(we1),
    .bus_wdata(wd1), .bus_rdata(rd1), .trig_n(trig1));

  int nchk = 0, nerr = 0;
  logic [95:0] m_in, m_st, m_se, m_mk;
  logic [2:0]  m_vc [96];

  function automatic logic [11:0] a_reg(input int kind, input int bank);
    return {4'b0, 2'(kind), 1'b0, 2'(bank), 3'b0};
  endfunction

  function automatic logic [11:0] a_vec(input int bank, input int line);
    return {2'b10, 2'(bank), 1'b0, 5'(line), 2'b0};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int b;
    if (a[11]) begin
      b = int'(a[9:8]);
      if (b >= 3) return '0;
      return {29'd0, m_vc[b*32 + int'(a[6:2])]};
    end
    b = int'(a[4:3]);
    if (b >= 3) return '0;
    case (a[7:6])
      2'd0:    return m_st[b*32 +: 32];
      2'd1:    return m_se[b*32 +: 32];
      2'd2:    return m_mk[b*32 +: 32];
      default: return '0;
    endcase
  endfunction

  function automatic logic [3:0] exp_trig();
    logic [3:0] h = '0;
    for (int l = 0; l < 96; l++)
      if (m_st[l] && m_mk[l] && m_vc[l] >= 3'd1 && m_vc[l] <= 3'd4) h[m_vc[l] - 3'd1] = 1'b1;
    return ~h;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    int b;
    @(negedge clk);
    addr = a; we = 1'b1; wd = d;
    @(negedge clk);
    we = 1'b0;
    if (a[11]) begin
      b = int'(a[9:8]);
      if (b < 3) m_vc[b*32 + int'(a[6:2])] = d[2:0];
    end else begin
      b = int'(a[4:3]);
      if (b < 3) begin
        case (a[7:6])
          2'd0: for (int i = 0; i < 32; i++) if (!m_se[b*32+i] && d[i]) m_st[b*32+i] = ~m_st[b*32+i];
          2'd1: begin
            m_se[b*32 +: 32] = d;
            m_st = (m_st & ~m_se) | (m_in & m_se);
          end
          2'd2: m_mk[b*32 +: 32] = d;
          default: ;
        endcase
      end
    end
    settle();
  endtask

  task automatic drive_in(input logic [95:0] v);
    for (int l = 0; l < 96; l++)
      if (!m_se[l] && v[l] && !m_in[l]) m_st[l] = 1'b1;
    m_in = v;
    m_st = (m_st & ~m_se) | (v & m_se);
    @(negedge clk);
    irq = v;
    settle();
  endtask

  task automatic brd(input string r, input logic [11:0] a);
    @(negedge clk);
    addr = a;
    #1 chk(r, rd, exp_rd(a));
  endtask

  task automatic ctrig(input string r);
    #1 chk(r, {28'd0, trig}, {28'd0, exp_trig()});
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; irq = '0; addr = '0; we = 1'b0; wd = '0;
    irq1 = '0; a1 = '0; we1 = 1'b0; wd1 = '0;
    m_in = '0; m_st = '0; m_se = '0; m_mk = '0;
    for (int l = 0; l < 96; l++) m_vc[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    ctrig("R1 trig after reset");
    for (int b = 0; b < 3; b++)
      for (int k = 0; k < 3; k++) brd("R1 reg after reset", a_reg(k, b));
    brd("R1 vec after reset", a_vec(0, 0));
    brd("R1 vec after reset", a_vec(2, 31));

    bwr(a_vec(0, 5), 32'd1);
    bwr(a_reg(2, 0), 32'h20);
    drive_in(96'h20);
    brd("R3 edge capture", a_reg(0, 0));
    ctrig("R10 thread0 asserted");
    drive_in(96'h0);
    brd("R3 falling keeps status", a_reg(0, 0));

    bwr(a_reg(0, 0), 32'h20);
    brd("R5 ack clears", a_reg(0, 0));
    ctrig("R5 ack releases trigger");
    bwr(a_reg(0, 0), 32'h0);
    brd("R5 write zero no effect", a_reg(0, 0));
    bwr(a_reg(0, 0), 32'h20);
    brd("R5 toggle sets", a_reg(0, 0));
    ctrig("R5 retrigger asserts");
    bwr(a_reg(0, 0), 32'h20);
    bwr(a_reg(0, 0), 32'h20);
    brd("R5 double toggle", a_reg(0, 0));

    bwr(a_reg(1, 1), 32'h8);
    brd("R6 sense readback", a_reg(1, 1));
    drive_in(96'h8 << 32);
    brd("R4 level follows high", a_reg(0, 1));
    bwr(a_reg(0, 1), 32'h8);
    brd("R4 level ignores write", a_reg(0, 1));

    bwr(a_vec(1, 3), 32'd3);
    ctrig("R7 mask blocks");
    brd("R7 status kept while masked", a_reg(0, 1));
    bwr(a_reg(2, 1), 32'h8);
    ctrig("R7 unmask asserts thread2");
    drive_in(96'h0);
    brd("R4 level follows low", a_reg(0, 1));
    ctrig("R4 level release");

    bwr(a_reg(2, 2), 32'h1);
    drive_in(96'h1 << 64);
    for (int c = 0; c < 8; c++) begin
      bwr(a_vec(2, 0), 32'(c));
      ctrig("R9 routing code");
      brd("R9 vector readback", a_vec(2, 0));
    end
    drive_in(96'h0);

    bwr(a_reg(0, 3), 32'hFFFF_FFFF);
    brd("R2 unused bank status", a_reg(0, 3));
    bwr(a_vec(3, 7), 32'd2);
    brd("R2 unused bank vector", a_vec(3, 7));
    bwr(a_reg(3, 0), 32'hFFFF_FFFF);
    brd("R2 kind3 reads zero", a_reg(3, 0));
    ctrig("R2 unused bank no trigger");

    for (int it = 0; it < 400; it++) begin
      int op, b;
      op = int'($urandom_range(0, 4));
      b = int'($urandom_range(0, 3));
      case (op)
        0: bwr(a_reg(0, b), $urandom);
        1: bwr(a_reg(1, b), $urandom);
        2: bwr(a_reg(2, b), $urandom);
        3: bwr(a_vec(b, int'($urandom_range(0, 31))), $urandom_range(0, 7));
        default: drive_in(m_in ^ {$urandom, $urandom, $urandom});
      endcase
      ctrig("R10 random trigger");
      if ($urandom_range(0, 3) == 0)
        brd("R9 random vector read", a_vec(int'($urandom_range(0, 3)), int'($urandom_range(0, 31))));
      else
        brd("R2 random reg read", a_reg(int'($urandom_range(0, 3)), int'($urandom_range(0, 3))));
    end

    @(negedge clk); a1 = 12'h800; we1 = 1'b1; wd1 = 32'd2;
    @(negedge clk); we1 = 1'b0; irq1 = 32'h1;
    settle();
    #1 chk("R8 no-mask routes", {28'd0, trig1}, 32'hD);
    @(negedge clk); a1 = 12'h080; we1 = 1'b1; wd1 = 32'h0;
    @(negedge clk); we1 = 1'b0;
    settle();
    #1 chk("R8 mask reads zero", rd1, 32'h0);
    chk("R8 mask write ignored", {28'd0, trig1}, 32'hD);
    @(negedge clk); a1 = 12'h000; we1 = 1'b1; wd1 = 32'h1;
    @(negedge clk); we1 = 1'b0;
    settle();
    #1 chk("R5 ack without mask", {28'd0, trig1}, 32'hF);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule